// File: doc/BRIEF.md
# Serial-Bus Node Core Register File

This block holds the core control and status registers of a serial-bus node. It serves single-quadlet read and write requests with a byte offset and a length. One cycle after each request it returns a response code and read data. The registers it keeps are the state pair, the node identifier, the split-transaction timeout pair, cycle time, bus time and the broadcast channel. Each register applies its own write mask.

Cycle time is not counted here. The free-running counter outside the block provides it on `cyc_now`, and the block samples that value whenever software reads cycle time or bus time. Each time a sample is smaller than the one before it, the counter has wrapped, so the stored bus-time seconds advance by one unit of 128. A cycle-time write does not change the counter directly. It is passed out as a one-cycle load pulse instead.

The split-timeout pair is turned into an expiry count of a fixed tick (125 µs by default). This count has a floor of 100 ms, and it is recomputed on the clock edge that takes either timeout write.

Top module: `sbus_csr_regfile`

## Requirements
- R1: After reset: split-timeout high reads 0, split-timeout low reads 800 << 19 (0x19000000), the broadcast channel reads 0x8000001F, `node_id` is 0, stored bus time is 0, the previous cycle sample is 0, `expiry_ticks` is 800 and `resp_valid` is 0.
- R2: A request whose offset has bits [1:0] nonzero, or whose length is not exactly 4, gets response code 6 (type error) and changes nothing.
- R3: The offset map is: 0x000 and 0x004 state, 0x008 node IDs, 0x00C reset-start, 0x018 and 0x01C split-timeout high and low, 0x200 cycle time, 0x204 bus time, 0x234 broadcast channel. Every other aligned offset, busy-timeout at 0x210 included, gets code 7 (address error). A read of reset-start gets code 6. A write to reset-start gets code 0 and changes nothing.
- R4: A split-timeout-high write keeps only bits [2:0]. A split-timeout-low write keeps only bits [31:19]. All other bits read back as 0.
- R5: `expiry_ticks` equals max(high × 1,000,000 + (low >> 19) × 125, 100,000) / 125. It updates on the same edge as the split-timeout write.
- R6: A cycle-time read returns `cyc_now`. When a cycle-time or bus-time read samples a value below the previous sample, stored bus time increases by 128 modulo 2^32. Each such read records its sample as the previous sample.
- R7: A bus-time read returns the stored bus time, after any increase from that same read, ORed with `cyc_now >> 25`. A bus-time write keeps only bits [31:7].
- R8: A cycle-time write raises `cyc_set_valid` for exactly one cycle, with `cyc_set_value` equal to the written word, and records that word as the previous sample.
- R9: In the broadcast channel only bit 30 is writable. Every other bit stays as in 0x8000001F.
- R10: A node-ID write replaces only the 10-bit bus number in bits [31:22]. The 6-bit node number in bits [21:16] is kept, and reads return the ID in [31:16] with zeros below. `node_ld` loads `node_num_in` into the node number. `node_id` outputs {bus number, node number}.
- R11: Offsets 0x000 and 0x004 read `STATE_INIT` (0 by default). Writes to them complete with code 0 and have no effect.
- R12: Every request is answered on the following cycle with `resp_valid` high and code 0 (complete), 6 or 7. The data is 0 for writes and for errors. With no request, `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (12) | Byte offset within the register space |
| req_len | input | LEN_W (8) | Request length in bytes |
| req_wdata | input | 32 | Write data |
| cyc_now | input | 32 | Current value of the external cycle-time counter |
| node_ld | input | 1 | Load the node number |
| node_num_in | input | 6 | Node number to load |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 4 | 0 complete, 6 type error, 7 address error |
| resp_rdata | output | 32 | Read data |
| cyc_set_valid | output | 1 | Load pulse for the external cycle-time counter |
| cyc_set_value | output | 32 | Value to load into the counter |
| node_id | output | 16 | Bus number and node number |
| expiry_ticks | output | EXP_W (16) | Split-transaction expiry in ticks |

## Verification
The bench builds the block with its defaults: a 12-bit offset, an 8-bit length, a 125 µs tick and a 100 ms floor. This gives a 16-bit expiry. At these values the largest timeout, 64191 ticks, sits just under the top of the output range, and the 800-tick floor is reached both by a zero timeout and by small nonzero timeouts. The sample values are chosen to produce two wraps on bus-time reads, including the wrap of a saturated bus time back to zero. They also exercise a wrap against a value placed by a cycle-time write.

// File: rtl/sbcsr_pkg.sv
package sbcsr_pkg;

  typedef enum logic [3:0] {
    RC_COMPLETE = 4'h0,
    RC_TYPE_ERR = 4'h6,
    RC_ADDR_ERR = 4'h7
  } rcode_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STATE,
    SEL_NODE,
    SEL_RSTART,
    SEL_STO_HI,
    SEL_STO_LO,
    SEL_CYC,
    SEL_BUS,
    SEL_BCAST
  } reg_sel_e;

  localparam logic [11:0] OFS_STATE_A = 12'h000;
  localparam logic [11:0] OFS_STATE_B = 12'h004;
  localparam logic [11:0] OFS_NODE    = 12'h008;
  localparam logic [11:0] OFS_RSTART  = 12'h00C;
  localparam logic [11:0] OFS_STO_HI  = 12'h018;
  localparam logic [11:0] OFS_STO_LO  = 12'h01C;
  localparam logic [11:0] OFS_CYC     = 12'h200;
  localparam logic [11:0] OFS_BUS     = 12'h204;
  localparam logic [11:0] OFS_BCAST   = 12'h234;

  localparam logic [12:0] STO_LO_RST  = 13'd800;
  localparam logic [31:0] BCAST_BASE  = 32'h8000_001F;

endpackage

// File: rtl/sbcsr_decode.sv
module sbcsr_decode
  import sbcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output reg_sel_e          sel,
  output rcode_e            code
);

  localparam logic [LEN_W-1:0] QUAD_LEN = LEN_W'(4);

  always_comb begin
    sel = SEL_NONE;
    case (req_addr)
      ADDR_W'(OFS_STATE_A),
      ADDR_W'(OFS_STATE_B): sel = SEL_STATE;
      ADDR_W'(OFS_NODE):    sel = SEL_NODE;
      ADDR_W'(OFS_RSTART):  sel = SEL_RSTART;
      ADDR_W'(OFS_STO_HI):  sel = SEL_STO_HI;
      ADDR_W'(OFS_STO_LO):  sel = SEL_STO_LO;
      ADDR_W'(OFS_CYC):     sel = SEL_CYC;
      ADDR_W'(OFS_BUS):     sel = SEL_BUS;
      ADDR_W'(OFS_BCAST):   sel = SEL_BCAST;
      default:              sel = SEL_NONE;
    endcase
  end

  always_comb begin
    if ((req_addr[1:0] != 2'b00) || (req_len != QUAD_LEN)) begin
      code = RC_TYPE_ERR;
    end else if (sel == SEL_NONE) begin
      code = RC_ADDR_ERR;
    end else if ((sel == SEL_RSTART) && !req_write) begin
      code = RC_TYPE_ERR;
    end else begin
      code = RC_COMPLETE;
    end
  end

endmodule

// File: rtl/sbcsr_split.sv
module sbcsr_split
  import sbcsr_pkg::*;
#(
  parameter int unsigned TICK_US = 125,
  parameter int unsigned MIN_US  = 100000,
  parameter int          EXP_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [2:0]       wdata_hi,
  input  logic [12:0]      wdata_lo,
  output logic [2:0]       hi_q,
  output logic [12:0]      lo_q,
  output logic [EXP_W-1:0] expiry_q
);

  function automatic logic [EXP_W-1:0] ticks_of(input logic [2:0] hi, input logic [12:0] lo);
    logic [31:0] usec;
    usec = (32'(hi) * 32'd1000000) + (32'(lo) * 32'd125);
    if (usec < 32'(MIN_US)) usec = 32'(MIN_US);
    return EXP_W'(usec / 32'(TICK_US));
  endfunction

  localparam logic [EXP_W-1:0] EXPIRY_RST = ticks_of(3'd0, STO_LO_RST);

  logic [2:0]       hi_d;
  logic [12:0]      lo_d;
  logic [EXP_W-1:0] expiry_d;
  logic             any_wr;

  assign any_wr = wr_hi | wr_lo;

  always_comb begin
    hi_d     = wr_hi ? wdata_hi : hi_q;
    lo_d     = wr_lo ? wdata_lo : lo_q;
    expiry_d = ticks_of(hi_d, lo_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 3'd0;
      lo_q     <= STO_LO_RST;
      expiry_q <= EXPIRY_RST;
    end else if (any_wr) begin
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      expiry_q <= expiry_d;
    end
  end

endmodule

// File: rtl/sbcsr_timebase.sv
module sbcsr_timebase (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_en,
  input  logic        cyc_wr,
  input  logic        bus_wr,
  input  logic [31:0] wdata,
  input  logic [31:0] cyc_now,
  output logic [31:0] bus_rd,
  output logic        cset_valid,
  output logic [31:0] cset_value
);

  logic [31:0] prev_q, prev_d;
  logic [24:0] secs_q, secs_d, secs_inc;
  logic        wrap;
  logic        prev_en, secs_en;

  assign wrap     = smp_en && (cyc_now < prev_q);
  assign secs_inc = secs_q + {24'd0, wrap};
  assign bus_rd   = {secs_inc, cyc_now[31:25]};

  assign prev_en = smp_en | cyc_wr;
  assign secs_en = smp_en | bus_wr;

  always_comb begin
    prev_d = cyc_wr ? wdata : cyc_now;
    secs_d = bus_wr ? wdata[31:7] : secs_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 32'd0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= 25'd0;
    end else if (secs_en) begin
      secs_q <= secs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cset_valid <= 1'b0;
    end else begin
      cset_valid <= cyc_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cset_value <= 32'd0;
    end else if (cyc_wr) begin
      cset_value <= wdata;
    end
  end

endmodule

// File: rtl/sbus_csr_regfile.sv
module sbus_csr_regfile
  import sbcsr_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          LEN_W      = 8,
  parameter int unsigned TICK_US    = 125,
  parameter int unsigned MIN_US     = 100000,
  parameter logic [31:0] STATE_INIT = 32'h0,
  parameter int          EXP_W      = $clog2((7 * 1000000 + 8191 * 125) / TICK_US + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       cyc_now,
  input  logic              node_ld,
  input  logic [5:0]        node_num_in,
  output logic              resp_valid,
  output logic [3:0]        resp_code,
  output logic [31:0]       resp_rdata,
  output logic              cyc_set_valid,
  output logic [31:0]       cyc_set_value,
  output logic [15:0]       node_id,
  output logic [EXP_W-1:0]  expiry_ticks
);

  reg_sel_e    sel;
  rcode_e      code;
  logic        hit, wr_hit, rd_hit;
  logic [2:0]  sto_hi;
  logic [12:0] sto_lo;
  logic [31:0] bus_rd;
  logic [31:0] rd_mux;

  logic [9:0]  busnum_q, busnum_d;
  logic [5:0]  nodenum_q, nodenum_d;
  logic        bcv_q, bcv_d;
  logic        busnum_en, nodenum_en, bcv_en;

  logic        rv_q;
  rcode_e      rc_q, rc_d;
  logic [31:0] rdata_q, rdata_d;

  sbcsr_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .sel       (sel),
    .code      (code)
  );

  assign hit    = req_valid && (code == RC_COMPLETE);
  assign wr_hit = hit && req_write;
  assign rd_hit = hit && !req_write;

  sbcsr_split #(.TICK_US(TICK_US), .MIN_US(MIN_US), .EXP_W(EXP_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (wr_hit && (sel == SEL_STO_HI)),
    .wr_lo    (wr_hit && (sel == SEL_STO_LO)),
    .wdata_hi (req_wdata[2:0]),
    .wdata_lo (req_wdata[31:19]),
    .hi_q     (sto_hi),
    .lo_q     (sto_lo),
    .expiry_q (expiry_ticks)
  );

  sbcsr_timebase u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (rd_hit && ((sel == SEL_CYC) || (sel == SEL_BUS))),
    .cyc_wr     (wr_hit && (sel == SEL_CYC)),
    .bus_wr     (wr_hit && (sel == SEL_BUS)),
    .wdata      (req_wdata),
    .cyc_now    (cyc_now),
    .bus_rd     (bus_rd),
    .cset_valid (cyc_set_valid),
    .cset_value (cyc_set_value)
  );

  // Node identifier and broadcast valid flag: next state
  always_comb begin
    busnum_en  = wr_hit && (sel == SEL_NODE);
    busnum_d   = req_wdata[31:22];
    nodenum_en = node_ld;
    nodenum_d  = node_num_in;
    bcv_en     = wr_hit && (sel == SEL_BCAST);
    bcv_d      = req_wdata[30];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busnum_q <= 10'd0;
    end else if (busnum_en) begin
      busnum_q <= busnum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nodenum_q <= 6'd0;
    end else if (nodenum_en) begin
      nodenum_q <= nodenum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcv_q <= BCAST_BASE[30];
    end else if (bcv_en) begin
      bcv_q <= bcv_d;
    end
  end

  assign node_id = {busnum_q, nodenum_q};

  // Read data selection
  always_comb begin
    case (sel)
      SEL_STATE:  rd_mux = STATE_INIT;
      SEL_NODE:   rd_mux = {busnum_q, nodenum_q, 16'h0000};
      SEL_STO_HI: rd_mux = {29'd0, sto_hi};
      SEL_STO_LO: rd_mux = {sto_lo, 19'd0};
      SEL_CYC:    rd_mux = cyc_now;
      SEL_BUS:    rd_mux = bus_rd;
      SEL_BCAST:  rd_mux = {BCAST_BASE[31], bcv_q, BCAST_BASE[29:0]};
      default:    rd_mux = 32'd0;
    endcase
  end

  // Response stage
  always_comb begin
    rc_d    = code;
    rdata_d = rd_hit ? rd_mux : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q    <= RC_COMPLETE;
      rdata_q <= 32'd0;
    end else if (req_valid) begin
      rc_q    <= rc_d;
      rdata_q <= rdata_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_code  = rc_q;
  assign resp_rdata = rdata_q;

endmodule

// File: rtl/sbcsr_checker.sv
module sbcsr_checker #(
  parameter int          ADDR_W  = 12,
  parameter int          LEN_W   = 8,
  parameter int unsigned TICK_US = 125,
  parameter int unsigned MIN_US  = 100000,
  parameter int          EXP_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [31:0]       req_wdata,
  input logic              node_ld,
  input logic              resp_valid,
  input logic [3:0]        resp_code,
  input logic [31:0]       resp_rdata,
  input logic              cyc_set_valid,
  input logic [31:0]       cyc_set_value,
  input logic [15:0]       node_id,
  input logic [EXP_W-1:0]  expiry_ticks
);

  localparam logic [EXP_W-1:0] EXP_FLOOR = EXP_W'(MIN_US / TICK_US);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R12

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R12

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_code != 4'h0)) |-> (resp_rdata == 32'd0)); // R12

  AST_MISALIGN_TYPE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_addr[1:0] != 2'b00) || (req_len != LEN_W'(4))))
      |=> (resp_valid && (resp_code == 4'h6))); // R2

  AST_EXPIRY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_ticks >= EXP_FLOOR); // R5

  AST_EXPIRY_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(expiry_ticks)); // R5

  AST_CSET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_addr == ADDR_W'(12'h200)) && (req_len == LEN_W'(4)))
      |=> (cyc_set_valid && (cyc_set_value == $past(req_wdata)))); // R8

  AST_CSET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !cyc_set_valid); // R8

  AST_NODE_NUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !node_ld |=> (node_id[5:0] == $past(node_id[5:0]))); // R10

  AST_BUSNUM_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(node_id[15:6])); // R10

endmodule

bind sbus_csr_regfile sbcsr_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .TICK_US(TICK_US),
  .MIN_US (MIN_US),
  .EXP_W  (EXP_W)
) u_sbcsr_checker (.*);

// File: tb/sbus_csr_regfile_bench.sv
`timescale 1ns/1ps
module sbus_csr_regfile_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [11:0] req_addr;
  logic [7:0]  req_len;
  logic [31:0] req_wdata;
  logic [31:0] cyc_now;
  logic        node_ld;
  logic [5:0]  node_num_in;
  logic        resp_valid;
  logic [3:0]  resp_code;
  logic [31:0] resp_rdata;
  logic        cyc_set_valid;
  logic [31:0] cyc_set_value;
  logic [15:0] node_id;
  logic [15:0] expiry_ticks;

  sbus_csr_regfile u_sbus_csr_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .cyc_now(cyc_now), .node_ld(node_ld), .node_num_in(node_num_in),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata),
    .cyc_set_valid(cyc_set_valid), .cyc_set_value(cyc_set_value),
    .node_id(node_id), .expiry_ticks(expiry_ticks)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  bit    live  = 0;
  string tag   = "R1";

  // Reference model state
  int unsigned m_bus, m_prev, m_hi, m_lo, m_busn, m_node, m_bcv;
  bit          e_rv, e_cs;
  int unsigned e_rc, e_rd, e_csv;
  int unsigned cyc_val;

  function automatic int unsigned ticks(int unsigned hi, int unsigned lo);
    longint unsigned us;
    us = longint'(hi) * 1000000 + longint'(lo) * 125;
    if (us < 100000) us = 100000;
    return int'(us / 125);
  endfunction

  task automatic chk(bit ok, string t, string what, int unsigned act, int unsigned expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, expv);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk(resp_valid == e_rv, tag, "resp_valid", resp_valid, e_rv);
      if (e_rv) begin
        chk(resp_code == e_rc[3:0], tag, "resp_code", resp_code, e_rc);
        chk(resp_rdata == e_rd, tag, "resp_rdata", resp_rdata, e_rd);
      end
      chk(expiry_ticks == ticks(m_hi, m_lo), tag, "expiry_ticks", expiry_ticks, ticks(m_hi, m_lo));
      chk(node_id == ((m_busn << 6) | m_node), tag, "node_id", node_id, (m_busn << 6) | m_node);
      chk(cyc_set_valid == e_cs, tag, "cyc_set_valid", cyc_set_valid, e_cs);
      if (e_cs) chk(cyc_set_value == e_csv, tag, "cyc_set_value", cyc_set_value, e_csv);
    end
  end

  task automatic req(bit wr, int unsigned addr, int unsigned len, int unsigned wd, string t);
    int unsigned rc, rd, n_bus, n_prev, n_hi, n_lo, n_busn, n_bcv;
    bit cs;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 12'(addr); req_len = 8'(len);
    req_wdata = wd; cyc_now = cyc_val; node_ld = 1'b0;
    n_bus = m_bus; n_prev = m_prev; n_hi = m_hi; n_lo = m_lo; n_busn = m_busn; n_bcv = m_bcv;
    rd = 0; cs = 0;
    if ((addr % 4) != 0 || len != 4) rc = 6;
    else begin
      rc = 0;
      case (addr)
        'h000, 'h004: rd = 0;
        'h008: if (wr) n_busn = wd >> 22; else rd = ((m_busn << 6) | m_node) << 16;
        'h00C: if (!wr) rc = 6;
        'h018: if (wr) n_hi = wd % 8; else rd = m_hi;
        'h01C: if (wr) n_lo = wd >> 19; else rd = m_lo << 19;
        'h200: begin
          if (wr) begin n_prev = wd; cs = 1; end
          else begin
            rd = cyc_val;
            if (cyc_val < m_prev) n_bus = m_bus + 128;
            n_prev = cyc_val;
          end
        end
        'h204: begin
          if (wr) n_bus = wd & 32'hFFFF_FF80;
          else begin
            if (cyc_val < m_prev) n_bus = m_bus + 128;
            n_prev = cyc_val;
            rd = n_bus | (cyc_val >> 25);
          end
        end
        'h234: if (wr) n_bcv = (wd >> 30) % 2; else rd = 32'h8000_001F | (m_bcv << 30);
        default: rc = 7;
      endcase
    end
    if (rc != 0 || wr) rd = 0;
    @(posedge clk);
    m_bus = n_bus; m_prev = n_prev; m_hi = n_hi; m_lo = n_lo; m_busn = n_busn; m_bcv = n_bcv;
    e_rv = 1; e_rc = rc; e_rd = rd; e_cs = cs; e_csv = wd; tag = t;
  endtask

  task automatic idle(int n, string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; node_ld = 1'b0;
      @(posedge clk);
      e_rv = 0; e_cs = 0; tag = t;
    end
  endtask

  task automatic load_node(int unsigned v);
    @(negedge clk);
    req_valid = 1'b0; node_ld = 1'b1; node_num_in = 6'(v);
    @(posedge clk);
    m_node = v; e_rv = 0; e_cs = 0; tag = "R10";
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_len = 0;
    req_wdata = 0; cyc_now = 0; node_ld = 0; node_num_in = 0; cyc_val = 0;
    m_bus = 0; m_prev = 0; m_hi = 0; m_lo = 800; m_busn = 0; m_node = 0; m_bcv = 0;
    e_rv = 0; e_cs = 0; e_rc = 0; e_rd = 0; e_csv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live  = 1'b1;
    idle(2, "R1");
    // R1 reset values read back
    req(0, 'h018, 4, 0, "R1");
    req(0, 'h01C, 4, 0, "R1");
    req(0, 'h234, 4, 0, "R1");
    req(0, 'h008, 4, 0, "R1");
    req(0, 'h204, 4, 0, "R1");
    // R4 write masks, R5 expiry
    req(1, 'h018, 4, 32'hFFFF_FFFF, "R4");
    req(0, 'h018, 4, 0, "R4");
    req(1, 'h01C, 4, 32'hFFFF_FFFF, "R5");
    req(0, 'h01C, 4, 0, "R4");
    req(1, 'h018, 4, 0, "R5");
    req(1, 'h01C, 4, 0, "R5");
    req(1, 'h01C, 4, 100 << 19, "R5");
    req(1, 'h01C, 4, (1000 << 19) | 32'h7FFFF, "R5");
    req(1, 'h018, 4, 2, "R5");
    idle(1, "R5");
    // R2 type errors leave state untouched
    req(1, 'h019, 4, 32'hFFFF_FFFF, "R2");
    req(1, 'h018, 8, 5, "R2");
    req(0, 'h018, 0, 0, "R2");
    req(1, 'h01E, 4, 0, "R2");
    req(0, 'h018, 4, 0, "R2");
    // R3 decode
    req(0, 'h010, 4, 0, "R3");
    req(1, 'h100, 4, 0, "R3");
    req(0, 'h210, 4, 0, "R3");
    req(1, 'h21C, 4, 0, "R3");
    req(0, 'h00C, 4, 0, "R3");
    req(1, 'h00C, 4, 32'hFFFF_FFFF, "R3");
    // R11 state pair
    req(1, 'h000, 4, 32'hFFFF_FFFF, "R11");
    req(1, 'h004, 4, 32'h1234_5678, "R11");
    req(0, 'h000, 4, 0, "R11");
    req(0, 'h004, 4, 0, "R11");
    // R6, R7 time base
    cyc_val = 32'h0000_1000; req(0, 'h200, 4, 0, "R6");
    cyc_val = 32'h0000_0800; req(0, 'h204, 4, 0, "R6");
    cyc_val = 32'hFE00_0000; req(0, 'h204, 4, 0, "R7");
    req(1, 'h204, 4, 32'hFFFF_FFFF, "R7");
    cyc_val = 32'h0000_0000; req(0, 'h204, 4, 0, "R7");
    cyc_val = 32'h0400_0000; req(0, 'h200, 4, 0, "R6");
    // R8 cycle-time write
    req(1, 'h200, 4, 32'h1234_5678, "R8");
    idle(1, "R8");
    cyc_val = 32'h1234_5600; req(0, 'h204, 4, 0, "R8");
    req(1, 'h200, 4, 32'h0000_0001, "R8");
    req(1, 'h200, 4, 32'hABCD_0000, "R8");
    idle(1, "R8");
    // R9 broadcast
    req(1, 'h234, 4, 0, "R9");
    req(0, 'h234, 4, 0, "R9");
    req(1, 'h234, 4, 32'hFFFF_FFFF, "R9");
    req(0, 'h234, 4, 0, "R9");
    req(1, 'h234, 4, 32'h4000_0000, "R9");
    req(0, 'h234, 4, 0, "R9");
    // R10 node IDs
    load_node(6'h2A);
    idle(1, "R10");
    req(1, 'h008, 4, 32'hFFFF_FFFF, "R10");
    req(0, 'h008, 4, 0, "R10");
    load_node(6'h05);
    req(1, 'h008, 4, 32'h0040_0000, "R10");
    req(0, 'h008, 4, 0, "R10");
    // R12 back-to-back then quiet
    req(0, 'h018, 4, 0, "R12");
    req(1, 'h200, 4, 32'h0000_0FFF, "R12");
    idle(3, "R12");
    done = 1;
    live = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule